// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Settle Tracking

This block turns a one-bit delta-sigma modulator stream into signed multi-bit conversion results. A strobe qualifies each modulator bit. Three cascaded integrators accumulate the bits, and three comb stages take differences once per output period. Each result therefore weighs the most recent 3·N modulator samples with the coefficients of (1 + z + … + z^(N−1))³. N is the programmable decimation ratio. An output period lasts N+1 strobes. N of them feed the integrators. The last one contributes no sample: it closes the period, runs the combs and hands the result to the output register.

Every period ends with a one-cycle data-ready pulse, and each result carries a valid flag. After reset, after a restart request or after a change of decimation ratio, the flag stays low until the filter window holds only fresh samples. A restart whose timing is unknown costs three invalid results. A restart that arrives before the first sample of a period costs two. The flag only tracks settling: restart never touches the filter arithmetic.

Top module: `sinc3_decimator`

## Requirements
- R1: Modulator bit 1 counts as +1 and bit 0 as −1. Each result equals the sum over the latest 3·N integrated samples weighted by the coefficients of (1+z+…+z^(N−1))³. Samples taken before reset count as zero. A constant stream of ones gives N³ and a constant stream of zeros gives −N³.
- R2: One output period is N+1 strobes. The first N strobes each integrate one sample. The (N+1)th strobe integrates nothing and closes the period. `dataReady` is high for exactly one cycle, the cycle after that closing strobe.
- R3: `result` is a 24-bit two's complement word (sign-extended from the accumulator, or its low 24 bits if the accumulator were wider). It changes only together with a `dataReady` pulse and holds its value between pulses. Reset clears it to zero.
- R4: The integrators wrap modulo 2^(1+3·ceil(log2(MAX_DECIM+1))). Full-scale inputs at the largest ratio still produce exactly ±N³.
- R5: During reset the block loads the ratio from `decimRatio` and leaves `dataReady` and `resultValid` low. After reset, the first two results are flagged invalid and the third is flagged valid.
- R6: A `restart` raised when at least one sample of the current period has already been integrated makes the next three results invalid and the fourth valid. If a period closes in the same cycle as the restart, that result is also flagged invalid and is not one of the three.
- R7: A `restart` raised before any sample of the current period has been integrated makes the next two results invalid and the third valid.
- R8: The block samples `decimRatio` only on the strobe that closes a period. A value that changes and returns to its old value before that strobe has no effect on period length or on validity.
- R9: When the ratio sampled at a period boundary differs from the active one, the next two results are flagged invalid and the third valid. An unchanged ratio leaves the validity count alone.
- R10: A requested ratio of 0 acts as 1. A request above MAX_DECIM acts as MAX_DECIM.
- R11: `resultValid` is only high together with `dataReady`. `dataReady` pulses every period whether or not the result is valid.
- R12: `restart` affects only the validity flags. The results that follow it keep the R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modBit | input | 1 | Modulator output bit |
| modStrobe | input | 1 | Qualifies `modBit` for one cycle at the modulator rate |
| decimRatio | input | RATIO_W | Requested decimation ratio N |
| restart | input | 1 | Input changed; restart settle tracking |
| dataReady | output | 1 | One-cycle pulse per output period |
| result | output | OUT_W | Conversion result, two's complement |
| resultValid | output | 1 | Result is settled (valid only with `dataReady`) |

## Verification
The bench sweeps ratios 1 to 12 with pseudo-random bits and random idle gaps between strobes. It also covers the clamped values 0 and 100, and it recomputes every result from a sample history and a closed-form sinc³ weight count. A design that integrated the closing strobe, or counted N strobes per period instead of N+1, would raise `dataReady` at the wrong strobe and put wrong values into the weighted sum. Restarts are applied in three positions: mid-period, at the start of a period, and on the closing strobe. A design that did not tell aligned from unaligned restarts, or that counted the coincident result, would flag the wrong result as the first valid one. The full-scale checks at the largest ratio catch an accumulator too narrow to wrap cleanly. A ratio wiggle that is undone before a boundary catches a design that samples `decimRatio` continuously.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  // Order of the sinc filter: integrator and comb stage count.
  localparam int SINC_ORDER = 3;

  // Per-cycle commands from control to datapath.
  typedef struct packed {
    logic integ;   // add the current modulator sample
    logic dump;    // close the period: run combs, load result
  } sincStrobe_t;

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int MAX_DECIM = 64,
  parameter int RATIO_W   = $clog2(MAX_DECIM + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modStrobe,
  input  logic               restart,
  input  logic [RATIO_W-1:0] decimRatio,
  output sincStrobe_t        strobe,
  output logic               dataReady,
  output logic               resultValid
);

  localparam logic [RATIO_W-1:0] MAX_RATIO = RATIO_W'(MAX_DECIM);
  localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(1);
  localparam logic [1:0] SKIP_ALIGNED = 2'd2;
  localparam logic [1:0] SKIP_ASYNC   = 2'd3;

  logic [RATIO_W-1:0] ratioReq;
  logic [RATIO_W-1:0] activeN;
  logic [RATIO_W-1:0] phase;
  logic [1:0]         skipLeft;
  logic               atBoundary;
  logic               dumpNow;
  logic               ratioChange;

  // Clamp requested ratio into the legal range.
  always_comb begin
    if (decimRatio == '0)            ratioReq = MIN_RATIO;
    else if (decimRatio > MAX_RATIO) ratioReq = MAX_RATIO;
    else                             ratioReq = decimRatio;
  end

  assign atBoundary   = (phase == activeN);
  assign dumpNow      = modStrobe && atBoundary;
  assign ratioChange  = (ratioReq != activeN);
  assign strobe.integ = modStrobe && !atBoundary;
  assign strobe.dump  = dumpNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= '0;
      activeN     <= ratioReq;
      skipLeft    <= SKIP_ALIGNED;
      dataReady   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      dataReady   <= dumpNow;
      resultValid <= dumpNow && (skipLeft == 2'd0) && !restart;

      if (dumpNow) begin
        phase   <= '0;
        activeN <= ratioReq;
      end else if (modStrobe) begin
        phase <= phase + 1'b1;
      end

      if (restart) begin
        skipLeft <= (phase == '0) ? SKIP_ALIGNED : SKIP_ASYNC;
      end else if (dumpNow) begin
        if (ratioChange)            skipLeft <= SKIP_ALIGNED;
        else if (skipLeft != 2'd0)  skipLeft <= skipLeft - 1'b1;
      end
    end
  end

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phase <= activeN);                                          // R2
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !dumpNow |=> $stable(activeN));                             // R8
  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (activeN != '0) && (activeN <= MAX_RATIO));                 // R10
  AST_RESTART_BLOCKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !resultValid);                                  // R6

endmodule

// File: rtl/sinc3_datapath.sv
module sinc3_datapath
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 22,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modBit,
  input  sincStrobe_t      strobe,
  output logic [OUT_W-1:0] result
);

  logic signed [ACC_W-1:0] integ    [SINC_ORDER];
  logic signed [ACC_W-1:0] integNext[SINC_ORDER];
  logic signed [ACC_W-1:0] combDly  [SINC_ORDER];
  logic signed [ACC_W-1:0] combTap  [SINC_ORDER];
  logic signed [ACC_W-1:0] combOut  [SINC_ORDER];
  logic signed [ACC_W-1:0] inStep;
  logic signed [ACC_W-1:0] combFinal;
  logic        [OUT_W-1:0] outWord;

  // Bit 1 -> +1, bit 0 -> -1 (all ones).
  assign inStep = modBit ? ACC_W'(1) : {ACC_W{1'b1}};

  generate
    for (genvar s = 0; s < SINC_ORDER; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign integNext[s] = integ[s] + inStep;
        assign combTap[s]   = integ[SINC_ORDER-1];
        assign combOut[s]   = integ[SINC_ORDER-1] - combDly[s];
      end else begin : g_rest
        assign integNext[s] = integ[s] + integNext[s-1];
        assign combTap[s]   = combOut[s-1];
        assign combOut[s]   = combOut[s-1] - combDly[s];
      end
    end
  endgenerate

  assign combFinal = combOut[SINC_ORDER-1];

  generate
    if (OUT_W > ACC_W) begin : g_extend
      assign outWord = {{(OUT_W-ACC_W){combFinal[ACC_W-1]}}, combFinal};
    end else if (OUT_W == ACC_W) begin : g_same
      assign outWord = combFinal;
    end else begin : g_trunc
      assign outWord = combFinal[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SINC_ORDER; s++) begin
        integ[s]   <= '0;
        combDly[s] <= '0;
      end
      result <= '0;
    end else begin
      for (int s = 0; s < SINC_ORDER; s++) begin
        if (strobe.integ) integ[s]   <= integNext[s];
        if (strobe.dump)  combDly[s] <= combTap[s];
      end
      if (strobe.dump) result <= outWord;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dump |=> $stable(result));                          // R3
  AST_NO_SAMPLE_ON_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.integ |=> $stable(integ[0]));                       // R2
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.integ, strobe.dump}));                     // R2

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter  int MAX_DECIM = 64,
  parameter  int OUT_W     = 24,
  localparam int RATIO_W   = $clog2(MAX_DECIM + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modBit,
  input  logic               modStrobe,
  input  logic [RATIO_W-1:0] decimRatio,
  input  logic               restart,
  output logic               dataReady,
  output logic [OUT_W-1:0]   result,
  output logic               resultValid
);

  localparam int ACC_W = 1 + SINC_ORDER * RATIO_W;

  sincStrobe_t strobe;

  sinc3_ctrl #(
    .MAX_DECIM (MAX_DECIM),
    .RATIO_W   (RATIO_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modStrobe   (modStrobe),
    .restart     (restart),
    .decimRatio  (decimRatio),
    .strobe      (strobe),
    .dataReady   (dataReady),
    .resultValid (resultValid)
  );

  sinc3_datapath #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .modBit (modBit),
    .strobe (strobe),
    .result (result)
  );

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> !dataReady);                                  // R2
  AST_READY_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> $past(modStrobe));                            // R2
  AST_VALID_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> dataReady);                                 // R11

endmodule

// File: tb/tb_sinc3_decimator.sv
module tb_sinc3_decimator;

  localparam int CLK_PERIOD = 10;
  localparam int MAXN       = 64;
  localparam int HIST       = 3 * MAXN;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modBit;
  logic        modStrobe;
  logic [6:0]  decimRatio;
  logic        restart;
  logic        dataReady;
  logic [23:0] result;
  logic        resultValid;

  sinc3_decimator dut (
    .clk         (clk),
    .rstN        (rstN),
    .modBit      (modBit),
    .modStrobe   (modStrobe),
    .decimRatio  (decimRatio),
    .restart     (restart),
    .dataReady   (dataReady),
    .result      (result),
    .resultValid (resultValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference model state, derived from the requirements.
  int mPhase, mN, mSkip, mMixed;
  int hist [HIST];
  logic [15:0] lfsr = 16'hACE1;
  longint lastResult;
  string validTag = "R5";
  string valueTag = "R1";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampN(input int r);
    if (r == 0) return 1;
    if (r > MAXN) return MAXN;
    return r;
  endfunction

  function automatic longint sincRef(input int n);
    longint acc = 0;
    for (int p = 0; p < 3*n; p++) begin
      longint w = 0;
      for (int a = 0; a < n; a++)
        for (int b = 0; b < n; b++) begin
          int c = p - a - b;
          if (c >= 0 && c < n) w++;
        end
      acc += w * hist[p];
    end
    return acc;
  endfunction

  function automatic bit nextBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Called at a falling edge; applies one cycle of stimulus and checks it.
  task automatic step(input bit s, input bit b, input bit rs);
    bit dumpNow, expValid, known;
    longint expVal;
    int newN;
    modStrobe = s; modBit = b; restart = rs;
    newN = clampN(int'(decimRatio));
    dumpNow = s && (mPhase == mN);
    expValid = 0; known = 0; expVal = 0;
    if (dumpNow) begin
      expVal = sincRef(mN);
      expValid = (mSkip == 0) && !rs;
      known = (mMixed == 0);
    end
    if (rs) mSkip = (mPhase == 0) ? 2 : 3;
    else if (dumpNow) begin
      if (newN != mN) mSkip = 2;
      else if (mSkip > 0) mSkip--;
    end
    if (dumpNow) begin
      if (mMixed > 0) mMixed--;
      if (newN != mN) mMixed = 2;
      mN = newN;
      mPhase = 0;
    end else if (s) begin
      for (int i = HIST-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = b ? 1 : -1;
      mPhase++;
    end
    @(posedge clk);
    @(negedge clk);
    modStrobe = 0; restart = 0;
    check(dataReady === dumpNow, "R2 dataReady", longint'(dataReady), longint'(dumpNow));
    if (dumpNow) begin
      check(resultValid === expValid, validTag, longint'(resultValid), longint'(expValid));
      if (known)
        check(longint'($signed(result)) == expVal, valueTag, longint'($signed(result)), expVal);
      lastResult = longint'($signed(result));
    end else begin
      check(resultValid === 1'b0, "R11 valid without ready", longint'(resultValid), 0);
      check(longint'($signed(result)) == lastResult, "R3 hold", longint'($signed(result)), lastResult);
    end
  endtask

  // pattern: 0 zeros, 1 ones, 2 pseudo-random with idle gaps
  task automatic runStrobes(input int count, input int pattern);
    for (int k = 0; k < count; k++) begin
      if (pattern == 2 && nextBit()) step(0, 0, 0);
      step(1, pattern == 2 ? nextBit() : pattern[0], 0);
    end
  endtask

  task automatic runPeriods(input int periods, input int pattern);
    runStrobes(periods * (mN + 1), pattern);
  endtask

  task automatic toBoundary();
    while (mPhase != mN) step(1, nextBit(), 0);
  endtask

  initial begin
    rstN = 0; modBit = 0; modStrobe = 0; restart = 0; decimRatio = 7'd4;
    mPhase = 0; mN = 4; mSkip = 2; mMixed = 0; lastResult = 0;
    for (int i = 0; i < HIST; i++) hist[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R5: reset state
    check(dataReady === 1'b0, "R5 reset ready", longint'(dataReady), 0);
    check(resultValid === 1'b0, "R5 reset valid", longint'(resultValid), 0);
    check(result === 24'd0, "R3 reset result", longint'(result), 0);

    // R5 / R1: ones from reset: -> partial, partial, then 64
    validTag = "R5 settle after reset";
    runPeriods(3, 1);
    check(lastResult == 64, "R1 ones N=4", lastResult, 64);
    validTag = "R11 valid each period";
    runPeriods(5, 2);

    // R6: restart mid-period
    validTag = "R6 async restart"; valueTag = "R12 value after restart";
    runStrobes(2, 2);
    step(1, nextBit(), 1);
    runPeriods(5, 2);

    // R7: aligned restart before first sample of a period
    validTag = "R7 aligned restart";
    toBoundary();
    step(1, 0, 0);
    step(0, 0, 1);
    runPeriods(4, 2);

    // R6: restart on the closing strobe
    validTag = "R6 restart at close";
    toBoundary();
    step(1, 0, 1);
    runPeriods(5, 2);
    valueTag = "R1";

    // R8: transient ratio change reverted before the boundary
    validTag = "R8 ignored ratio wiggle";
    toBoundary();
    step(1, 0, 0);
    runStrobes(1, 2);
    decimRatio = 7'd7;
    runStrobes(1, 2);
    decimRatio = 7'd4;
    runPeriods(4, 2);

    // R9: real ratio change
    validTag = "R9 ratio change";
    runStrobes(1, 2);
    decimRatio = 7'd3;
    runPeriods(6, 2);

    // R10: clamp low
    validTag = "R10 ratio 0 acts as 1";
    decimRatio = 7'd0;
    runPeriods(8, 2);
    check(mN == 1, "R10 clamp low", mN, 1);

    // R10 / R4: clamp high and full scale at the largest ratio
    validTag = "R10 ratio above max"; valueTag = "R4 full scale";
    decimRatio = 7'd100;
    toBoundary();
    step(1, 0, 0);
    runPeriods(4, 1);
    check(lastResult == 262144, "R4 +full scale", lastResult, 262144);
    runPeriods(3, 0);
    check(lastResult == -262144, "R4 -full scale", lastResult, -262144);
    valueTag = "R1";

    // R9 / R1: sweep of ratios with pseudo-random streams
    validTag = "R9 sweep";
    for (int n = 1; n <= 12; n++) begin
      decimRatio = 7'(n);
      toBoundary();
      step(1, 0, 0);
      runPeriods(5, 2);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule